// File: doc/BRIEF.md
# Linear CCD drive timing generator

This block turns a fast master clock into the digital drive waveforms of a four-row linear CCD scanner sensor. It produces:

- the two complementary transfer clocks;
- the reset gate and the clamp gate;
- four shift-gate lines, where gate 0 serves the monochrome row and gates 1 to 3 serve the three colour rows;
- two changeover-switch levels that select colour or monochrome readout.

All timing is counted in master clock ticks. The defaults assume 40 ticks per element period, which is a 40 MHz master clock at a 1 MHz element rate. With those defaults every pulse width and lead sits inside the sensor's limits:

| Timing | Default |
|---|---|
| Reset pulse | 50 ns |
| Per-pixel clamp pulse | 50 ns |
| Phase-1 lead before the shift pulse | 200 ns |
| Shift pulse width | 4 us |
| Phase-1 hold after the shift pulse | 900 ns |
| Line-clamp lead | 50 ns |

A line consists of a transfer window followed by a readout. In the transfer window phase 1 stays high, the selected shift-gate group pulses, and in line-clamp mode the clamp gate rises a few ticks ahead of the shift pulse. The readout then runs one element period per element. Alongside the waveforms the block gives an element index and a segment tag, so that downstream capture logic can separate signal elements from dummy and light-shield elements.

The line time is the integration time. It is taken from a period input, measured in elements, and raised to the readout length if it is shorter. Mode, clamp mode and period are sampled only at a line boundary.

A start request is remembered until it is consumed. A request raised during a line therefore begins the next line directly after the last element. Holding the start input high gives back-to-back lines.

Top module: `ccd_drive_tg`

## Requirements
- R1: While reset is low and after its release with no start request, the outputs are idle: phi1_o=0, phi2_o=1, rs_o=0, cp_o=0, shg_o=4'b0001, sw1_o=1, sw2_o=0, seg_o=0, pix_o=0.
- R2: Colour mode (mono_i=0) holds sw1_o=1, sw2_o=0 and shg_o[0]=1, and pulses shg_o[3:1] together during the shift pulse. The default readout is 5490 elements.
- R3: Monochrome mode (mono_i=1) holds sw1_o=0, sw2_o=1 and shg_o[3:1]=3'b111, and pulses only shg_o[0]. The default readout is 2745 elements.
- R4: The transfer window lasts PRE+SH_T+POST ticks with phi1_o=1, phi2_o=0 and rs_o=0. The shift pulse spans ticks PRE to PRE+SH_T-1 of the window. Its first tick appears PRE+1 clock edges after the edge that samples the start request.
- R5: During readout, phi1_o is high for the first TPE/2 ticks of each element and phi2_o is its complement. rs_o is high for RS_W ticks starting at tick RS_POS.
- R6: In per-pixel clamp mode (lclamp_i=0), cp_o is high for CP_W ticks starting RS_POS+RS_W+CP_GAP ticks into each element. It is never high during the transfer window.
- R7: In line-clamp mode (lclamp_i=1), cp_o is high for SH_T ticks starting CP_LEAD ticks before the shift pulse, and gives no per-element pulse.
- R8: During readout, pix_o counts elements from 0. seg_o encodes 1 = dummy, 2 = light-shield, 3 = signal and 0 = none. Colour readout has COL_PRE dummy elements, then COL_SHIELD shield elements, then COL_SIG signal elements; monochrome uses MONO_PRE, MONO_SHIELD and MONO_SIG in the same order. The defaults are 54/96/5340 for colour and 27/48/2670 for monochrome.
- R9: A line reads max(iper_i, readout length) elements. Elements past the readout carry seg_o=0 while pix_o keeps counting.
- R10: mono_i, lclamp_i and iper_i changed mid-line have no effect until the next line boundary. Both switch levels change on the first transfer tick, PRE ticks ahead of the shift pulse.
- R11: A start request raised during a line starts the next transfer on the tick after the last element. With no request pending, the block returns to the idle levels of R1 and keeps the latched mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Line start request (held as pending until consumed) |
| mono_i | input | 1 | 0 = colour, 1 = monochrome, sampled at line boundary |
| lclamp_i | input | 1 | 0 = per-pixel clamp, 1 = line clamp, sampled at line boundary |
| iper_i | input | IW | Line/integration period in elements |
| phi1_o | output | 1 | Transfer clock phase 1 |
| phi2_o | output | 1 | Transfer clock phase 2 |
| rs_o | output | 1 | Reset gate |
| cp_o | output | 1 | Clamp gate |
| shg_o | output | 4 | Shift gates; bit 0 monochrome row, bits 3:1 colour rows |
| sw1_o | output | 1 | Changeover switch 1 (high in colour) |
| sw2_o | output | 1 | Changeover switch 2 (high in monochrome) |
| seg_o | output | 2 | Segment tag of the current element |
| pix_o | output | IW | Index of the current element |

## Verification
Two events can land in the same cycle: the last tick of a line's final element, and the application of a new mode and clamp setting together with a queued start request. The bench provokes this by starting a colour per-pixel line, switching the mode and clamp inputs mid-line, and pulsing start again well before the line ends. It then judges both sides of the boundary. The final element must still carry colour switch levels and index 9. The very next tick must already show monochrome switch levels with phase 1 raised, and the line-clamp pulse must follow two ticks later.

// File: rtl/ccd_tg_pkg.sv
// Shared types for the CCD drive timing generator.
// Assumes: four shift-gate lines; segment tag codes are fixed by the brief.
package ccd_tg_pkg;

    localparam int NSH = 4;

    typedef enum logic [1:0] {
        SEG_NONE   = 2'd0,
        SEG_DUMMY  = 2'd1,
        SEG_SHIELD = 2'd2,
        SEG_SIGNAL = 2'd3
    } seg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_READ = 2'd2
    } seq_st_t;

    typedef struct packed {
        logic phi1;
        logic phi2;
        logic rs;
        logic cp;
        logic sh_act;
    } wave_t;

endpackage

// File: rtl/ccd_tg_seq.sv
// Line sequencer: idle / transfer window / readout, with tick and element
// counters. Latches mode, clamp mode and line length at each line boundary.
// Assumes: TPE >= 2, XF_LEN >= 1, both readout lengths fit in IW bits.
module ccd_tg_seq
    import ccd_tg_pkg::*;
#(
    parameter int TPE      = 40,
    parameter int XF_LEN   = 204,
    parameter int COL_LEN  = 5490,
    parameter int MONO_LEN = 2745,
    parameter int IW       = 16,
    localparam int KW      = $clog2(TPE + 1),
    localparam int XW      = $clog2(XF_LEN + 1)
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic          start_i,
    input  logic          mono_i,
    input  logic          lclamp_i,
    input  logic [IW-1:0] iper_i,
    output seq_st_t       st_o,
    output logic [XW-1:0] xt_o,
    output logic [KW-1:0] k_o,
    output logic [IW-1:0] e_o,
    output logic          mono_o,
    output logic          lclamp_o
);

    localparam logic [KW-1:0] K_LAST  = KW'(TPE - 1);
    localparam logic [XW-1:0] X_LAST  = XW'(XF_LEN - 1);
    localparam logic [IW-1:0] COL_W   = IW'(COL_LEN);
    localparam logic [IW-1:0] MONO_W  = IW'(MONO_LEN);

    seq_st_t       st_q;
    logic [XW-1:0] xt_q;
    logic [KW-1:0] k_q;
    logic [IW-1:0] e_q;
    logic [IW-1:0] len_q;
    logic          mono_q;
    logic          lc_q;
    logic          pend_q;

    logic          req;
    logic          elem_last;
    logic          line_last;
    logic          boundary;
    logic [IW-1:0] rd_min;
    logic [IW-1:0] len_next;

    // Boundary detection and clamped line length for the next line.
    always_comb begin
        req       = pend_q | start_i;
        elem_last = (k_q == K_LAST);
        line_last = (st_q == ST_READ) && elem_last && (e_q == len_q - IW'(1));
        boundary  = req && ((st_q == ST_IDLE) || line_last);
        rd_min    = mono_i ? MONO_W : COL_W;
        len_next  = (iper_i < rd_min) ? rd_min : iper_i;
    end

    // Sequencer state, counters and boundary-latched settings.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            st_q   <= ST_IDLE;
            xt_q   <= '0;
            k_q    <= '0;
            e_q    <= '0;
            len_q  <= COL_W;
            mono_q <= 1'b0;
            lc_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            pend_q <= boundary ? 1'b0 : req;
            if (boundary) begin
                st_q   <= ST_XFER;
                xt_q   <= '0;
                k_q    <= '0;
                e_q    <= '0;
                len_q  <= len_next;
                mono_q <= mono_i;
                lc_q   <= lclamp_i;
            end else begin
                case (st_q)
                    ST_XFER: begin
                        if (xt_q == X_LAST) begin
                            st_q <= ST_READ;
                            k_q  <= '0;
                            e_q  <= '0;
                        end else begin
                            xt_q <= xt_q + XW'(1);
                        end
                    end
                    ST_READ: begin
                        if (elem_last) begin
                            k_q <= '0;
                            if (line_last) begin
                                st_q <= ST_IDLE;
                                e_q  <= '0;
                            end else begin
                                e_q <= e_q + IW'(1);
                            end
                        end else begin
                            k_q <= k_q + KW'(1);
                        end
                    end
                    default: begin
                        xt_q <= '0;
                        k_q  <= '0;
                        e_q  <= '0;
                    end
                endcase
            end
        end
    end

    assign st_o     = st_q;
    assign xt_o     = xt_q;
    assign k_o      = k_q;
    assign e_o      = e_q;
    assign mono_o   = mono_q;
    assign lclamp_o = lc_q;

endmodule

// File: rtl/ccd_tg_wave.sv
// Waveform decoder: turns sequencer state and tick position into the
// transfer clocks, reset gate, clamp gate and the shift-pulse window.
// Assumes: CP_LEAD <= PRE and all pulse positions lie inside their window.
module ccd_tg_wave
    import ccd_tg_pkg::*;
#(
    parameter int TPE     = 40,
    parameter int RS_POS  = 20,
    parameter int RS_W    = 2,
    parameter int CP_GAP  = 0,
    parameter int CP_W    = 2,
    parameter int PRE     = 8,
    parameter int CP_LEAD = 2,
    parameter int SH_T    = 160,
    parameter int XF_LEN  = 204,
    localparam int KW     = $clog2(TPE + 1),
    localparam int XW     = $clog2(XF_LEN + 1)
) (
    input  seq_st_t       st_i,
    input  logic [XW-1:0] xt_i,
    input  logic [KW-1:0] k_i,
    input  logic          lclamp_i,
    output wave_t         wave_o
);

    localparam logic [XW-1:0] SH_ON  = XW'(PRE);
    localparam logic [XW-1:0] SH_OFF = XW'(PRE + SH_T);
    localparam logic [XW-1:0] LC_ON  = XW'(PRE - CP_LEAD);
    localparam logic [XW-1:0] LC_OFF = XW'(PRE - CP_LEAD + SH_T);
    localparam logic [KW-1:0] HALF   = KW'(TPE / 2);
    localparam logic [KW-1:0] RS_ON  = KW'(RS_POS);
    localparam logic [KW-1:0] RS_OFF = KW'(RS_POS + RS_W);
    localparam logic [KW-1:0] PX_ON  = KW'(RS_POS + RS_W + CP_GAP);
    localparam logic [KW-1:0] PX_OFF = KW'(RS_POS + RS_W + CP_GAP + CP_W);

    // Decode the drive levels for the present tick.
    always_comb begin
        wave_o = '{phi1: 1'b0, phi2: 1'b1, rs: 1'b0, cp: 1'b0, sh_act: 1'b0};
        case (st_i)
            ST_XFER: begin
                wave_o.phi1   = 1'b1;
                wave_o.phi2   = 1'b0;
                wave_o.sh_act = (xt_i >= SH_ON) && (xt_i < SH_OFF);
                wave_o.cp     = lclamp_i && (xt_i >= LC_ON) && (xt_i < LC_OFF);
            end
            ST_READ: begin
                wave_o.phi1 = (k_i < HALF);
                wave_o.phi2 = !(k_i < HALF);
                wave_o.rs   = (k_i >= RS_ON) && (k_i < RS_OFF);
                wave_o.cp   = !lclamp_i && (k_i >= PX_ON) && (k_i < PX_OFF);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ccd_tg_gate.sv
// Shift-gate and changeover-switch mapping. In colour mode the monochrome
// row gate is held high and the colour gates pulse; in monochrome mode
// the opposite holds. Assumes: bit 0 is the monochrome row gate.
module ccd_tg_gate
    import ccd_tg_pkg::*;
(
    input  logic           mono_i,
    input  logic           sh_act_i,
    output logic [NSH-1:0] shg_o,
    output logic           sw1_o,
    output logic           sw2_o
);

    for (genvar g = 0; g < NSH; g++) begin : g_sh
        if (g == 0) begin : g_mono_row
            // Monochrome row gate: pulsed in monochrome, parked high in colour.
            assign shg_o[g] = mono_i ? sh_act_i : 1'b1;
        end else begin : g_col_row
            // Colour row gate: pulsed in colour, parked high in monochrome.
            assign shg_o[g] = mono_i ? 1'b1 : sh_act_i;
        end
    end

    // Switch levels follow the latched line mode.
    assign sw1_o = !mono_i;
    assign sw2_o = mono_i;

endmodule

// File: rtl/ccd_tg_seg.sv
// Segment classifier: tags each readout element as dummy, light-shield,
// signal or none, and exposes the element index during readout.
// Assumes: segment lengths per mode fit in IW bits.
module ccd_tg_seg
    import ccd_tg_pkg::*;
#(
    parameter int COL_PRE     = 54,
    parameter int COL_SHIELD  = 96,
    parameter int COL_SIG     = 5340,
    parameter int MONO_PRE    = 27,
    parameter int MONO_SHIELD = 48,
    parameter int MONO_SIG    = 2670,
    parameter int IW          = 16
) (
    input  seq_st_t       st_i,
    input  logic [IW-1:0] e_i,
    input  logic          mono_i,
    output seg_t          seg_o,
    output logic [IW-1:0] pix_o
);

    localparam logic [IW-1:0] C_A = IW'(COL_PRE);
    localparam logic [IW-1:0] C_B = IW'(COL_PRE + COL_SHIELD);
    localparam logic [IW-1:0] C_C = IW'(COL_PRE + COL_SHIELD + COL_SIG);
    localparam logic [IW-1:0] M_A = IW'(MONO_PRE);
    localparam logic [IW-1:0] M_B = IW'(MONO_PRE + MONO_SHIELD);
    localparam logic [IW-1:0] M_C = IW'(MONO_PRE + MONO_SHIELD + MONO_SIG);

    logic [IW-1:0] lim_a;
    logic [IW-1:0] lim_b;
    logic [IW-1:0] lim_c;

    // Pick the segment limits of the latched mode and classify the element.
    always_comb begin
        lim_a = mono_i ? M_A : C_A;
        lim_b = mono_i ? M_B : C_B;
        lim_c = mono_i ? M_C : C_C;
        seg_o = SEG_NONE;
        pix_o = '0;
        if (st_i == ST_READ) begin
            pix_o = e_i;
            if (e_i < lim_a)      seg_o = SEG_DUMMY;
            else if (e_i < lim_b) seg_o = SEG_SHIELD;
            else if (e_i < lim_c) seg_o = SEG_SIGNAL;
            else                  seg_o = SEG_NONE;
        end
    end

endmodule

// File: rtl/ccd_drive_tg.sv
// Top of the linear CCD drive timing generator. Wires the sequencer,
// waveform decoder, gate mapping and segment classifier, and registers
// every output so the drive pins are glitch-free.
// Assumes: one master clock; all timing parameters in master ticks.
module ccd_drive_tg
    import ccd_tg_pkg::*;
#(
    parameter int TPE         = 40,
    parameter int RS_POS      = 20,
    parameter int RS_W        = 2,
    parameter int CP_GAP      = 0,
    parameter int CP_W        = 2,
    parameter int PRE         = 8,
    parameter int CP_LEAD     = 2,
    parameter int SH_T        = 160,
    parameter int POST        = 36,
    parameter int COL_PRE     = 54,
    parameter int COL_SHIELD  = 96,
    parameter int COL_SIG     = 5340,
    parameter int MONO_PRE    = 27,
    parameter int MONO_SHIELD = 48,
    parameter int MONO_SIG    = 2670,
    parameter int IW          = 16
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic          start_i,
    input  logic          mono_i,
    input  logic          lclamp_i,
    input  logic [IW-1:0] iper_i,
    output logic          phi1_o,
    output logic          phi2_o,
    output logic          rs_o,
    output logic          cp_o,
    output logic [3:0]    shg_o,
    output logic          sw1_o,
    output logic          sw2_o,
    output logic [1:0]    seg_o,
    output logic [IW-1:0] pix_o
);

    localparam int XF_LEN   = PRE + SH_T + POST;
    localparam int COL_LEN  = COL_PRE + COL_SHIELD + COL_SIG;
    localparam int MONO_LEN = MONO_PRE + MONO_SHIELD + MONO_SIG;
    localparam int KW       = $clog2(TPE + 1);
    localparam int XW       = $clog2(XF_LEN + 1);
    localparam logic [NSH-1:0] SHG_IDLE = NSH'(1);

    seq_st_t        st;
    logic [XW-1:0]  xt;
    logic [KW-1:0]  k;
    logic [IW-1:0]  e;
    logic           mono_q;
    logic           lc_q;
    wave_t          wave;
    logic [NSH-1:0] shg_d;
    logic           sw1_d;
    logic           sw2_d;
    seg_t           seg_d;
    logic [IW-1:0]  pix_d;

    ccd_tg_seq #(
        .TPE(TPE), .XF_LEN(XF_LEN), .COL_LEN(COL_LEN),
        .MONO_LEN(MONO_LEN), .IW(IW)
    ) u_seq (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .start_i(start_i),
        .mono_i(mono_i), .lclamp_i(lclamp_i), .iper_i(iper_i),
        .st_o(st), .xt_o(xt), .k_o(k), .e_o(e),
        .mono_o(mono_q), .lclamp_o(lc_q)
    );

    ccd_tg_wave #(
        .TPE(TPE), .RS_POS(RS_POS), .RS_W(RS_W), .CP_GAP(CP_GAP),
        .CP_W(CP_W), .PRE(PRE), .CP_LEAD(CP_LEAD), .SH_T(SH_T),
        .XF_LEN(XF_LEN)
    ) u_wave (
        .st_i(st), .xt_i(xt), .k_i(k), .lclamp_i(lc_q), .wave_o(wave)
    );

    ccd_tg_gate u_gate (
        .mono_i(mono_q), .sh_act_i(wave.sh_act),
        .shg_o(shg_d), .sw1_o(sw1_d), .sw2_o(sw2_d)
    );

    ccd_tg_seg #(
        .COL_PRE(COL_PRE), .COL_SHIELD(COL_SHIELD), .COL_SIG(COL_SIG),
        .MONO_PRE(MONO_PRE), .MONO_SHIELD(MONO_SHIELD), .MONO_SIG(MONO_SIG),
        .IW(IW)
    ) u_seg (
        .st_i(st), .e_i(e), .mono_i(mono_q), .seg_o(seg_d), .pix_o(pix_d)
    );

    // Output register stage: one tick behind the sequencer state.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            phi1_o <= 1'b0;
            phi2_o <= 1'b1;
            rs_o   <= 1'b0;
            cp_o   <= 1'b0;
            shg_o  <= SHG_IDLE;
            sw1_o  <= 1'b1;
            sw2_o  <= 1'b0;
            seg_o  <= SEG_NONE;
            pix_o  <= '0;
        end else begin
            phi1_o <= wave.phi1;
            phi2_o <= wave.phi2;
            rs_o   <= wave.rs;
            cp_o   <= wave.cp;
            shg_o  <= shg_d;
            sw1_o  <= sw1_d;
            sw2_o  <= sw2_d;
            seg_o  <= seg_d;
            pix_o  <= pix_d;
        end
    end

endmodule

// File: rtl/ccd_drive_tg_chk.sv
// Assertion checker for ccd_drive_tg, attached by bind. Observes the
// registered drive pins plus the latched clamp mode.
module ccd_drive_tg_chk #(
    parameter int SH_T = 160,
    parameter int IW   = 16
) (
    input logic          clk_i,
    input logic          rst_n_i,
    input logic          phi1_o,
    input logic          rs_o,
    input logic          cp_o,
    input logic [3:0]    shg_o,
    input logic          sw1_o,
    input logic [1:0]    seg_o,
    input logic [IW-1:0] pix_o,
    input logic          lc_i
);

    logic        pulsed;
    logic [15:0] hi_cnt;

    // The shift-gate group that pulses in the current mode.
    assign pulsed = sw1_o ? shg_o[1] : shg_o[0];

    // Count consecutive ticks with the pulsed group high.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) hi_cnt <= '0;
        else if (pulsed) hi_cnt <= hi_cnt + 16'd1;
        else hi_cnt <= '0;
    end

    p_sh_width_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(pulsed) |-> hi_cnt == 16'(SH_T));

    p_sh_in_phi1_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        pulsed |-> (phi1_o && $past(phi1_o)));

    p_rs_cp_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !(rs_o && cp_o));

    p_no_cp_xfer_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($rose(pulsed) && !lc_i) |-> !cp_o);

    p_cp_leads_sh_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($rose(pulsed) && lc_i) |-> $past(cp_o));

    p_pix_step_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (seg_o != 2'd0 && $past(seg_o) != 2'd0) |->
        (pix_o == $past(pix_o) || pix_o == $past(pix_o) + IW'(1)));

    p_sw_at_xfer_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !$stable(sw1_o) |-> (phi1_o && !$past(phi1_o)));

endmodule

bind ccd_drive_tg ccd_drive_tg_chk #(.SH_T(SH_T), .IW(IW)) u_chk (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .phi1_o(phi1_o), .rs_o(rs_o),
    .cp_o(cp_o), .shg_o(shg_o), .sw1_o(sw1_o), .seg_o(seg_o),
    .pix_o(pix_o), .lc_i(lc_q)
);

// File: tb/ccd_drive_tg_tb_top.sv
`timescale 1ns/1ps
// Bench for ccd_drive_tg with shrunken timing: 8 ticks per element,
// transfer window of 11 ticks (shift pulse at ticks 3..8, line clamp 2..7),
// colour readout 2+3+5 elements, monochrome 1+2+2 elements.
module ccd_drive_tg_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       mode = 1'b0;
    logic       lc = 1'b0;
    logic [7:0] ip = 8'd0;

    logic       phi1, phi2, rs, cp, sw1, sw2;
    logic [3:0] shg;
    logic [1:0] seg;
    logic [7:0] pix;

    int checks = 0;
    int failures = 0;
    int cur = 0;

    always #2.5 clk = ~clk;

    ccd_drive_tg #(
        .TPE(8), .RS_POS(4), .RS_W(1), .CP_GAP(0), .CP_W(1),
        .PRE(3), .CP_LEAD(1), .SH_T(6), .POST(2),
        .COL_PRE(2), .COL_SHIELD(3), .COL_SIG(5),
        .MONO_PRE(1), .MONO_SHIELD(2), .MONO_SIG(2), .IW(8)
    ) dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .start_i(start), .mono_i(mode),
        .lclamp_i(lc), .iper_i(ip), .phi1_o(phi1), .phi2_o(phi2),
        .rs_o(rs), .cp_o(cp), .shg_o(shg), .sw1_o(sw1), .sw2_o(sw2),
        .seg_o(seg), .pix_o(pix)
    );

    // Vector: {req[4], mode, lclamp, iper[8], pos[8], exp[12], pix[8]}
    // exp = {phi1, phi2, rs, cp, shg[3:0], sw1, sw2, seg[1:0]}
    // pos = tick of the line: 0..10 transfer, then 8 ticks per element.
    localparam int NV = 26;
    localparam logic [41:0] VECS [0:NV-1] = '{
        {4'd2,  1'b0, 1'b0, 8'd0,  8'd0,   12'b1000_0001_1000, 8'd0}, // R2 colour transfer start
        {4'd4,  1'b0, 1'b0, 8'd0,  8'd3,   12'b1000_1111_1000, 8'd0}, // R4 shift pulse first tick
        {4'd7,  1'b0, 1'b1, 8'd0,  8'd2,   12'b1001_0001_1000, 8'd0}, // R7 clamp leads shift
        {4'd7,  1'b0, 1'b1, 8'd0,  8'd8,   12'b1000_1111_1000, 8'd0}, // R7 clamp ends first
        {4'd7,  1'b0, 1'b1, 8'd0,  8'd7,   12'b1001_1111_1000, 8'd0}, // R7 clamp overlaps shift
        {4'd4,  1'b0, 1'b0, 8'd0,  8'd9,   12'b1000_0001_1000, 8'd0}, // R4 phase-1 hold after shift
        {4'd8,  1'b0, 1'b0, 8'd0,  8'd11,  12'b1000_0001_1001, 8'd0}, // R8 first dummy
        {4'd5,  1'b0, 1'b0, 8'd0,  8'd15,  12'b0110_0001_1001, 8'd0}, // R5 phase swap + reset
        {4'd6,  1'b0, 1'b0, 8'd0,  8'd16,  12'b0101_0001_1001, 8'd0}, // R6 per-pixel clamp
        {4'd7,  1'b0, 1'b1, 8'd0,  8'd16,  12'b0100_0001_1001, 8'd0}, // R7 no per-pixel clamp
        {4'd8,  1'b0, 1'b0, 8'd0,  8'd27,  12'b1000_0001_1010, 8'd2}, // R8 first shield
        {4'd8,  1'b0, 1'b0, 8'd0,  8'd51,  12'b1000_0001_1011, 8'd5}, // R8 first signal
        {4'd5,  1'b0, 1'b0, 8'd0,  8'd90,  12'b0100_0001_1011, 8'd9}, // R5 last tick of line
        {4'd3,  1'b1, 1'b0, 8'd0,  8'd0,   12'b1000_1110_0100, 8'd0}, // R3 mono switches
        {4'd3,  1'b1, 1'b0, 8'd0,  8'd3,   12'b1000_1111_0100, 8'd0}, // R3 mono row pulses
        {4'd3,  1'b1, 1'b0, 8'd0,  8'd11,  12'b1000_1110_0101, 8'd0}, // R3 mono dummy
        {4'd8,  1'b1, 1'b0, 8'd0,  8'd19,  12'b1000_1110_0110, 8'd1}, // R8 mono shield
        {4'd8,  1'b1, 1'b0, 8'd0,  8'd35,  12'b1000_1110_0111, 8'd3}, // R8 mono signal
        {4'd6,  1'b1, 1'b0, 8'd0,  8'd48,  12'b0101_1110_0111, 8'd4}, // R6 mono clamp pulse
        {4'd11, 1'b0, 1'b0, 8'd0,  8'd91,  12'b0100_0001_1000, 8'd0}, // R11 colour idle after line
        {4'd11, 1'b1, 1'b0, 8'd0,  8'd51,  12'b0100_1110_0100, 8'd0}, // R11 mono idle after line
        {4'd9,  1'b0, 1'b0, 8'd15, 8'd130, 12'b0100_0001_1000, 8'd14},// R9 extended line tail
        {4'd9,  1'b0, 1'b0, 8'd15, 8'd131, 12'b0100_0001_1000, 8'd0}, // R9 extended line ends
        {4'd9,  1'b0, 1'b0, 8'd3,  8'd83,  12'b1000_0001_1011, 8'd9}, // R9 short period clamped
        {4'd9,  1'b1, 1'b1, 8'd7,  8'd63,  12'b0110_1110_0100, 8'd6}, // R9 mono overscan element
        {4'd7,  1'b1, 1'b1, 8'd0,  8'd2,   12'b1001_1110_0100, 8'd0}  // R7 mono line clamp
    };

    task automatic check(input int req, input logic [11:0] exp,
                         input logic [7:0] epix, input string what);
        logic [11:0] got;
        got = {phi1, phi2, rs, cp, shg, sw1, sw2, seg};
        checks++;
        if (got !== exp || pix !== epix) begin
            failures++;
            $display("FAIL R%0d %s: got %b pix=%0d, expected %b pix=%0d",
                     req, what, got, pix, exp, epix);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic launch(input logic m, input logic l, input logic [7:0] i);
        mode  = m;
        lc    = l;
        ip    = i;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cur   = -1;
    endtask

    task automatic wait_pos(input int p);
        while (cur < p) begin
            @(negedge clk);
            cur++;
        end
    endtask

    initial begin
        do_reset();
        // R1: idle levels with reset released and no request
        check(1, 12'b0100_0001_1000, 8'd0, "idle after reset");
        repeat (4) @(negedge clk);
        check(1, 12'b0100_0001_1000, 8'd0, "idle holds without start");
        rst_n = 1'b0;
        start = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(1, 12'b0100_0001_1000, 8'd0, "reset dominates start");
        start = 1'b0;

        for (int v = 0; v < NV; v++) begin
            do_reset();
            launch(VECS[v][37], VECS[v][36], VECS[v][35:28]);
            wait_pos(int'(VECS[v][27:20]));
            check(int'(VECS[v][41:38]), VECS[v][19:8], VECS[v][7:0],
                  $sformatf("vector %0d pos %0d", v, VECS[v][27:20]));
        end

        // R10/R11: mode and clamp changed mid-line, second start queued
        do_reset();
        launch(1'b0, 1'b0, 8'd0);
        wait_pos(20);
        mode = 1'b1;
        lc   = 1'b1;
        wait_pos(27);
        check(10, 12'b1000_0001_1010, 8'd2, "mid-line mode change ignored");
        wait_pos(32);
        check(10, 12'b0101_0001_1010, 8'd2, "mid-line clamp change ignored");
        wait_pos(40);
        start = 1'b1;
        wait_pos(41);
        start = 1'b0;
        wait_pos(90);
        check(11, 12'b0100_0001_1011, 8'd9, "last element still colour");
        wait_pos(91);
        check(11, 12'b1000_1110_0100, 8'd0, "queued start: next transfer at once");
        wait_pos(93);
        check(10, 12'b1001_1110_0100, 8'd0, "new clamp mode at boundary");
        wait_pos(94);
        check(10, 12'b1001_1111_0100, 8'd0, "switches lead shift pulse");
        wait_pos(102);
        check(3, 12'b1000_1110_0101, 8'd0, "second line uses mono layout");
        wait_pos(142);
        check(11, 12'b0100_1110_0100, 8'd0, "idle keeps latched mono mode");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: run did not complete, got timeout, expected end");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule